// File: doc/BRIEF.md
# Single-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 18-bit words with a depth of 256, 512 or 1024 entries, chosen by a parameter. Writer and reader share one clock. A word can be stored and another delivered on the same rising edge. Read data leaves through a register. A word appears on `rd_data` one edge after its read is accepted, and the register holds that value until the next accepted read.

Occupancy is reported through five active-low flags: empty, full, more-than-half-full, almost-empty and almost-full. The almost thresholds are two run-time offsets. A separate loader block presents them on `ae_ofs_in` and `af_ofs_in` and strobes `ofs_load`. Reset restores both offsets to depth/8 - 1.

The data ports follow a stream discipline with active-low requests. `full_n` high plays the part of ready for the writer. `empty_n` high plays the part of valid for the reader. A request made while the matching flag is low is back-pressured: it is dropped, and the requester must hold its word and retry. Nothing is queued at the edge of the block.

Top module: `sfifo_pflag`

## Requirements
- R1: On a rising edge with `wr_en_n` low and `full_n` high, `wr_data` is stored. A write request while `full_n` is low stores nothing, and the flags keep the value they would have from any read on that edge alone.
- R2: On a rising edge with `rd_en_n` low and `empty_n` high, the oldest word is loaded into `rd_data`. While `rd_en_n` is high, `rd_data` keeps its value.
- R3: A read request while `empty_n` is low is ignored: `rd_data` and the occupancy are unchanged.
- R4: While `rst_n` is low, the buffer is emptied and `rd_data` is cleared to zero. `full_n`, `afull_n` and `half_n` read 1, `empty_n` and `aempty_n` read 0, and both offsets return to depth/8 - 1.
- R5: `empty_n` is 0 exactly when no word is stored. `full_n` is 0 exactly when DEPTH words are stored. The two are never low together.
- R6: `half_n` is 0 exactly when the stored count is greater than DEPTH/2.
- R7: `aempty_n` is 0 exactly when the count is at or below the almost-empty offset. An empty buffer therefore always shows `aempty_n` low.
- R8: `afull_n` is 0 exactly when the count is at or above DEPTH minus the almost-full offset. A full buffer therefore always shows `afull_n` low.
- R9: On a rising edge with `ofs_load` high, both offset inputs are captured. The flags use the new offsets from the following cycle.
- R10: A read and a write accepted on the same edge leave the count, and so all flags, unchanged.
- R11: Words leave in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | WIDTH (18) | Word to store |
| rd_en_n | input | 1 | Active-low read request |
| rd_data | output | WIDTH (18) | Registered read word |
| ofs_load | input | 1 | Strobe that captures both offset inputs |
| ae_ofs_in | input | log2(DEPTH) | New almost-empty offset |
| af_ofs_in | input | log2(DEPTH) | New almost-full offset |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |
| aempty_n | output | 1 | Low when count <= almost-empty offset |
| afull_n | output | 1 | Low when count >= DEPTH - almost-full offset |

## Verification
The bench walks the count through every threshold edge, in both directions, under the default and under loaded offsets. A one-off comparison (`<` against `<=`) shows up there as a flag that flips one word early or late. It pushes a distinctive word at a full buffer and requests both ports together at full and at empty. A design that stores into a full buffer, or lets a write through on a read-at-full edge, leaves an extra word in the drain order, and the scoreboard sees it. It also issues reads on an empty buffer and sits idle with reads disabled. A design that loads the output register regardless of the request corrupts `rd_data`. A mid-run reset must clear `rd_data` and bring back the default thresholds, so stale offsets or a stale output register are caught.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // reset value of both threshold offsets
  function automatic int dflt_ofs(input int depth);
    return depth / 8 - 1;
  endfunction

  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic half_n;
    logic aempty_n;
    logic afull_n;
  } flags_t;
endpackage

// File: rtl/sfifo_ptr_ctrl.sv
module sfifo_ptr_ctrl #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          rd_en_n,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] occ
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wr_nxt, rd_nxt;

  assign wr_fire = !wr_en_n && (occ != FULL_CNT);
  assign rd_fire = !rd_en_n && (occ != '0);

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_mod
      assign wr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_nxt;
      if (rd_fire) rd_ptr <= rd_nxt;
      unique case ({wr_fire, rd_fire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_fire,
  input  logic [AW-1:0]    rd_ptr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_fire) ram[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_fire) rd_data <= ram[rd_ptr];
  end
endmodule

// File: rtl/sfifo_ofs_regs.sv
module sfifo_ofs_regs #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ofs_load,
  input  logic [AW-1:0] ae_in,
  input  logic [AW-1:0] af_in,
  output logic [AW-1:0] ae_ofs,
  output logic [AW-1:0] af_ofs
);
  localparam logic [AW-1:0] DFLT = AW'(sfifo_pkg::dflt_ofs(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ofs <= DFLT;
      af_ofs <= DFLT;
    end else if (ofs_load) begin
      ae_ofs <= ae_in;
      af_ofs <= af_in;
    end
  end
endmodule

// File: rtl/sfifo_flag_gen.sv
module sfifo_flag_gen
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int CW    = 9
) (
  input  logic [CW-1:0] occ,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW-1:0] af_ofs,
  output flags_t        flags
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [CW-1:0] af_level;

  assign af_level = FULL_CNT - {1'b0, af_ofs};

  always_comb begin
    flags.empty_n  = (occ != '0);
    flags.full_n   = (occ != FULL_CNT);
    flags.half_n   = !(occ > HALF_CNT);
    flags.aempty_n = !(occ <= {1'b0, ae_ofs});
    flags.afull_n  = !(occ >= af_level);
  end
endmodule

// File: rtl/sfifo_pflag.sv
module sfifo_pflag
  import sfifo_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  input  logic             ofs_load,
  input  logic [AW-1:0]    ae_ofs_in,
  input  logic [AW-1:0]    af_ofs_in,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             aempty_n,
  output logic             afull_n
);
  logic          wr_fire, rd_fire;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic [AW-1:0] ae_ofs, af_ofs;
  flags_t        flags;

  sfifo_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ)
  );

  sfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .rd_fire(rd_fire), .rd_ptr(rd_ptr), .rd_data(rd_data)
  );

  sfifo_ofs_regs #(.DEPTH(DEPTH), .AW(AW)) u_ofs (
    .clk(clk), .rst_n(rst_n), .ofs_load(ofs_load),
    .ae_in(ae_ofs_in), .af_in(af_ofs_in),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  sfifo_flag_gen #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_flags (
    .occ(occ), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .flags(flags)
  );

  assign empty_n  = flags.empty_n;
  assign full_n   = flags.full_n;
  assign half_n   = flags.half_n;
  assign aempty_n = flags.aempty_n;
  assign afull_n  = flags.afull_n;
endmodule

// File: rtl/sfifo_pflag_chk.sv
module sfifo_pflag_chk #(
  parameter int WIDTH = 18,
  parameter int CW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_n,
  input logic             rd_en_n,
  input logic [WIDTH-1:0] rd_data,
  input logic             empty_n,
  input logic             full_n,
  input logic             aempty_n,
  input logic             afull_n,
  input logic [CW-1:0]    occ
);
  // R1: a full buffer with no read stays full
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && rd_en_n) |=> !full_n);

  // R2: output register holds while reads are off
  a_r2_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |=> $stable(rd_data));

  // R3: nothing leaves an empty buffer
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_data));

  // R5: empty and full are exclusive
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!empty_n, !full_n}));

  // R7: empty implies almost-empty
  a_r7_empty_in_ae: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  // R8: full implies almost-full
  a_r8_full_in_af: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  // R10: paired accepted read and write keep the count
  a_r10_pair_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && !rd_en_n && empty_n && full_n) |=> $stable(occ));
endmodule

bind sfifo_pflag sfifo_pflag_chk #(.WIDTH(WIDTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
  .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
  .aempty_n(aempty_n), .afull_n(afull_n), .occ(occ)
);

// File: tb/sfifo_pflag_bench.sv
module sfifo_pflag_bench;
  localparam int WIDTH = 18;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);
  localparam int DFLT  = DEPTH / 8 - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en_n = 1'b1;
  logic             rd_en_n = 1'b1;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic             ofs_load = 1'b0;
  logic [AW-1:0]    ae_ofs_in = '0;
  logic [AW-1:0]    af_ofs_in = '0;
  logic             empty_n, full_n, half_n, aempty_n, afull_n;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model
  logic [WIDTH-1:0] exp_q[$];
  int               m_cnt = 0;
  int               m_ae = DFLT;
  int               m_af = DFLT;
  logic [WIDTH-1:0] m_last = '0;
  bit               m_rd_go = 1'b0;

  always #4 clk = ~clk;

  sfifo_pflag #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_sfifo_pflag (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_en_n(rd_en_n), .rd_data(rd_data), .ofs_load(ofs_load),
    .ae_ofs_in(ae_ofs_in), .af_ofs_in(af_ofs_in),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
    .aempty_n(aempty_n), .afull_n(afull_n)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (count %0d)", what, act, exp, m_cnt);
    end
  endtask

  task automatic check_flags();
    chk("R5 empty_n", 32'(empty_n), 32'(m_cnt != 0));
    chk("R5 full_n", 32'(full_n), 32'(m_cnt != DEPTH));
    chk("R6 half_n", 32'(half_n), 32'(!(m_cnt > DEPTH / 2)));
    chk("R7 aempty_n", 32'(aempty_n), 32'(!(m_cnt <= m_ae)));
    chk("R8 afull_n", 32'(afull_n), 32'(!(m_cnt >= DEPTH - m_af)));
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic step(input bit w, input bit r, input logic [WIDTH-1:0] d);
    bit wacc, racc;
    wacc = w && (m_cnt < DEPTH);
    racc = r && (m_cnt > 0);
    wr_en_n = !w;
    rd_en_n = !r;
    wr_data = d;
    m_rd_go = racc;
    if (wacc) exp_q.push_back(d);
    m_cnt = m_cnt + int'(wacc) - int'(racc);
    @(posedge clk);
    #2;
    check_flags();
    @(negedge clk);
    wr_en_n = 1'b1;
    rd_en_n = 1'b1;
    m_rd_go = 1'b0;
  endtask

  // monitor: pops the scoreboard on accepted reads (R11), else expects a hold (R2)
  always @(posedge clk) begin
    bit go;
    go = m_rd_go;
    #2;
    if (go) begin
      logic [WIDTH-1:0] e;
      e = exp_q.pop_front();
      chk("R11 read order", 32'(rd_data), 32'(e));
      m_last = e;
    end else begin
      chk("R2 rd_data hold", 32'(rd_data), 32'(m_last));
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    exp_q.delete();
    m_cnt = 0;
    m_ae = DFLT;
    m_af = DFLT;
    m_last = '0;
    #1;
    chk("R4 rd_data cleared", 32'(rd_data), 32'h0);
    chk("R4 empty_n", 32'(empty_n), 32'h0);
    chk("R4 aempty_n", 32'(aempty_n), 32'h0);
    chk("R4 full_n", 32'(full_n), 32'h1);
    chk("R4 afull_n", 32'(afull_n), 32'h1);
    chk("R4 half_n", 32'(half_n), 32'h1);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 50000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R3: reads on an empty buffer change nothing
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, '0);
      chk("R3 rd_data on empty read", 32'(rd_data), 32'h0);
    end

    // R1 R5-R8: fill through every default threshold
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 18'((i * 37 + 5) & 18'h3FFFF));
    chk("R5 full reached", 32'(full_n), 32'h0);

    // R1: write at full is dropped; drain order later exposes a leak
    step(1'b1, 1'b0, 18'h3ABCD);
    chk("R1 full_n after write at full", 32'(full_n), 32'h0);
    // R1: paired request at full: read taken, write dropped
    step(1'b1, 1'b1, 18'h15555);
    chk("R1 count after paired at full", 32'(full_n), 32'h1);

    // R10: paired traffic in the middle keeps the count
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 18'(20000 + i));
    chk("R10 full_n after pairs", 32'(full_n), 32'h1);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, '0);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 18'(30000 + i));
    chk("R10 half_n after pairs", 32'(half_n), 32'(!(m_cnt > DEPTH / 2)));

    // R2: idle with reads disabled
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, '0);

    // drain through all thresholds downward
    while (m_cnt > 0) step(1'b0, 1'b1, '0);
    chk("R5 empty after drain", 32'(empty_n), 32'h0);

    // R3 R1: paired request at empty: only the write lands
    step(1'b1, 1'b1, 18'h2F0F0);
    chk("R3 empty_n after paired at empty", 32'(empty_n), 32'h1);
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    chk("R3 rd_data after empty read", 32'(rd_data), 32'h2F0F0);

    // R9: load new offsets, then sweep up and down
    ae_ofs_in = AW'(5);
    af_ofs_in = AW'(10);
    ofs_load = 1'b1;
    m_ae = 5;
    m_af = 10;
    step(1'b0, 1'b0, '0);
    ofs_load = 1'b0;
    chk("R9 aempty_n at empty with new offset", 32'(aempty_n), 32'h0);
    for (int i = 0; i < 250; i++) begin
      step(1'b1, 1'b0, 18'(i ^ 18'h2AAAA));
      if (m_cnt == 6) chk("R9 aempty_n rises at 6", 32'(aempty_n), 32'h1);
      if (m_cnt == 246) chk("R9 afull_n falls at 246", 32'(afull_n), 32'h0);
    end
    while (m_cnt > 0) step(1'b0, 1'b1, '0);

    // R4: reset mid-run restores defaults and clears output
    for (int i = 0; i < 40; i++) step(1'b1, (i % 3) == 0, 18'(i + 777));
    do_reset();
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, 18'(i + 4000));
      if (m_cnt == 32) chk("R4 default ae offset after reset", 32'(aempty_n), 32'h1);
    end
    while (m_cnt > 0) step(1'b0, 1'b1, '0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule